// File: doc/BRIEF.md
# Pipelined Bus Transaction Phase Tracker

This block follows bus transactions that overlap in time. Every transaction walks through six phases in a fixed order: arbitration, request, error check, snoop, response and data transfer. Each phase holds at most one transaction, so up to six transactions can be in flight at once, each in a different phase. A master hands in a request that carries the direction, a start address, a byte count, a tag and a parity bit. The block moves each transaction forward when the next phase can take it and stalls it when it cannot.

The error-check phase tests parity over the direction and the address. The snoop phase waits for an external consistency result. The response phase takes an external response code. Three outcomes end the transaction at the response phase: a parity failure, a refusal and a deferral. A deferral means the transaction is pending and the master must issue it again later. A transaction that completes at once goes to the data phase. That phase moves one bus word per clock until the byte count is used up. Each transaction ends with one report on a single completion port.

Top module: `bt_phase_tracker`

## Requirements
- R1: While reset is held and right after it, `phase_busy` is 0, `done_valid` is 0 and `req_ready` is 1.
- R2: The `phase_busy` bits are bit0 arbitration, bit1 request, bit2 error check, bit3 snoop, bit4 response and bit5 data. A transaction that meets no stall spends one clock in each of the first five phases. A transaction that ends at the response phase has `done_valid` high in the cycle after the fifth clock edge that follows its acceptance edge.
- R3: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low while the arbitration phase is occupied and `arb_grant` is low.
- R4: The request is good when `req_par` equals the XOR of `req_write` and every `req_addr` bit (even parity). A mismatch ends the transaction with status 2'b10. It makes no data beats and reports `done_hit` as 0.
- R5: A transaction that failed parity passes the snoop and response phases without waiting for `snp_valid` or `rsp_valid`. For it, `snp_ack` and `rsp_ack` stay low.
- R6: A good transaction waits in the snoop phase until `snp_valid` is high. `snp_ack` marks the edge on which it leaves. The `snp_hit` value sampled on that edge is reported as `done_hit`.
- R7: In the response phase, `rsp_code` 2'b00 sends the transaction to the data phase. 2'b01 ends it as deferred (status 2'b01). 2'b10 and 2'b11 end it as refused (status 2'b11). `rsp_ack` marks the edge on which the response is taken.
- R8: The data phase raises `dat_beat` on each clock that `dat_ready` is high, for ceil(bytes/WORD_BYTES) beats. `dat_addr` starts at the start address and steps by WORD_BYTES. A byte count of zero leaves after one clock with no beat. The completion then reports status 2'b00, with `done_valid` 5 + max(1, beats) cycles after acceptance when nothing stalls.
- R9: A transaction moves only when the next phase is empty or is being vacated on the same edge. Transactions issued back to back therefore fill all six phases and finish one per clock.
- R10: When the data phase finishes in the same cycle as the response phase wants to end a transaction, the data completion is reported first. The response phase holds for that cycle with `rsp_ack` low.
- R11: `done_tag` returns the tag of the transaction that is reported. Transactions complete in the order they were accepted, unless an earlier one stalls in a phase that a later one never reaches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New request offered |
| req_ready | output | 1 | Arbitration phase can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start address |
| req_bytes | input | CNT_W | Byte count |
| req_tag | input | TAG_W | Transaction tag |
| req_par | input | 1 | Even parity over direction and address |
| arb_grant | input | 1 | Bus granted to the arbitration occupant |
| snp_valid | input | 1 | Snoop result available |
| snp_hit | input | 1 | Snoop found a consistency hit |
| snp_ack | output | 1 | Snoop result taken this edge |
| rsp_valid | input | 1 | Response code available |
| rsp_code | input | 2 | 00 now, 01 deferred, 10/11 refused |
| rsp_ack | output | 1 | Response taken this edge |
| dat_ready | input | 1 | Data bus can move a word |
| dat_beat | output | 1 | A word moves this cycle |
| dat_write | output | 1 | Direction of the data occupant |
| dat_addr | output | ADDR_W | Address of the current word |
| dat_tag | output | TAG_W | Tag of the data occupant |
| phase_busy | output | 6 | Occupancy of each phase |
| done_valid | output | 1 | Completion report valid |
| done_tag | output | TAG_W | Tag of the completed transaction |
| done_status | output | 2 | 00 ok, 01 deferred, 10 parity, 11 refused |
| done_hit | output | 1 | Snoop result of the completed transaction |

## Verification
The bench builds the block with the default parameters: 16-bit addresses, 8-bit byte counts, 4-bit tags and four-byte words. A four-byte word makes counts of 0, 3, 5, 8 and 16 give zero, one, two, two and four beats. That brings rounding, the empty transfer and address stepping within a few cycles. With six phases and one-cycle phases, six back-to-back requests fill the pipe. A two-beat transfer followed by a refusal makes the completion-port collision happen on a known edge.

// File: rtl/bt_pkg.sv
// Shared codes for the bus transaction phase tracker.
// Assumes: status and response codes are two bits wide.
package bt_pkg;

    localparam int NUM_PHASES = 6;

    // Completion status reported on the done port.
    typedef enum logic [1:0] {
        ST_OK     = 2'b00,
        ST_DEFER  = 2'b01,
        ST_PARITY = 2'b10,
        ST_REFUSE = 2'b11
    } bt_status_e;

    // Response code given to the response phase.
    typedef enum logic [1:0] {
        RC_NOW    = 2'b00,
        RC_DEFER  = 2'b01,
        RC_REFUSE = 2'b10,
        RC_RSVD   = 2'b11
    } bt_rsp_e;

endpackage

// File: rtl/bt_slot.sv
// One phase register: holds a single transaction record and an occupied flag.
// Assumes: a load on the same edge as a clear means a new occupant replaces
// the departing one.
module bt_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clear,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         occ
);

    // Capture an incoming record or free the slot when its occupant leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= 1'b0;
            q   <= '0;
        end else if (load) begin
            occ <= 1'b1;
            q   <= d;
        end else if (clear) begin
            occ <= 1'b0;
        end
    end

endmodule

// File: rtl/bt_parity_chk.sv
// Even-parity check over the command direction bit and the address.
// Assumes: the master sets par so that XOR of {write, addr, par} is zero.
module bt_parity_chk #(
    parameter int ADDR_W = 16
) (
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic              par,
    output logic              bad
);

    // Compare the carried parity with the recomputed one.
    always_comb begin
        bad = ((^{write, addr}) != par);
    end

endmodule

// File: rtl/bt_data_engine.sv
// Data-transfer phase: moves one word per ready clock until the byte count
// is used up, then signals finish.
// Assumes: a zero byte count finishes after one clock with no beat.
module bt_data_engine #(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 8,
    parameter int TAG_W      = 4,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ld_write,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_bytes,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic              ld_hit,
    input  logic              dat_ready,
    output logic              busy,
    output logic              finish,
    output logic              beat,
    output logic              cur_write,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [TAG_W-1:0]  cur_tag,
    output logic              cur_hit
);

    localparam logic [CNT_W-1:0]  STEP_BYTES = CNT_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP_ADDR  = ADDR_W'(WORD_BYTES);

    logic [CNT_W-1:0] rem_q;

    // Decide whether a word moves and whether this is the last clock.
    always_comb begin
        beat   = busy && dat_ready && (rem_q != '0);
        finish = busy && ((rem_q == '0) || (dat_ready && (rem_q <= STEP_BYTES)));
    end

    // Occupancy of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (load) begin
            busy <= 1'b1;
        end else if (finish) begin
            busy <= 1'b0;
        end
    end

    // Record fields, address stepping and remaining byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_tag   <= '0;
            cur_hit   <= 1'b0;
            rem_q     <= '0;
        end else if (load) begin
            cur_write <= ld_write;
            cur_addr  <= ld_addr;
            cur_tag   <= ld_tag;
            cur_hit   <= ld_hit;
            rem_q     <= ld_bytes;
        end else if (beat) begin
            cur_addr  <= cur_addr + STEP_ADDR;
            rem_q     <= (rem_q <= STEP_BYTES) ? '0 : (rem_q - STEP_BYTES);
        end
    end

endmodule

// File: rtl/bt_phase_tracker.sv
// Tracks up to six overlapping bus transactions, one per phase:
// arbitration, request, error check, snoop, response, data transfer.
// Each phase advances only into an empty or emptying successor; outcomes
// are reported one per clock on a registered completion port.
// Assumes: snoop and response inputs refer to the current occupant of
// their phase and are held until acknowledged.
module bt_phase_tracker #(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 8,
    parameter int TAG_W      = 4,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_bytes,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_par,
    input  logic              arb_grant,
    input  logic              snp_valid,
    input  logic              snp_hit,
    output logic              snp_ack,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_code,
    output logic              rsp_ack,
    input  logic              dat_ready,
    output logic              dat_beat,
    output logic              dat_write,
    output logic [ADDR_W-1:0] dat_addr,
    output logic [TAG_W-1:0]  dat_tag,
    output logic [5:0]        phase_busy,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag,
    output logic [1:0]        done_status,
    output logic              done_hit
);

    import bt_pkg::*;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  bytes;
        logic [TAG_W-1:0]  tag;
        logic              par;
        logic              perr;
        logic              hit;
    } rec_t;

    localparam int REC_W   = $bits(rec_t);
    localparam int N_SLOTS = NUM_PHASES - 1;
    localparam int P_ERR   = 2;
    localparam int P_SNP   = 3;
    localparam int P_RSP   = 4;

    logic [REC_W-1:0] slot_d [N_SLOTS];
    logic [REC_W-1:0] slot_q [N_SLOTS];
    logic [N_SLOTS-1:0] occ;
    logic [N_SLOTS-1:0] load;
    logic [N_SLOTS-1:0] leave;
    logic [N_SLOTS:0]   free_v;
    logic [N_SLOTS-1:0] gate;

    rec_t    rec_in, err_rec, snp_rec, rsp_rec;
    logic    perr_now;
    bt_rsp_e code_e;
    logic    dat_busy, dat_finish, dat_hit;
    logic    to_data, exit_rsp;

    // Assemble the record for a fresh request.
    always_comb begin
        rec_in       = '0;
        rec_in.write = req_write;
        rec_in.addr  = req_addr;
        rec_in.bytes = req_bytes;
        rec_in.tag   = req_tag;
        rec_in.par   = req_par;
    end

    assign err_rec = rec_t'(slot_q[P_ERR]);
    assign snp_rec = rec_t'(slot_q[P_SNP]);
    assign rsp_rec = rec_t'(slot_q[P_RSP]);
    assign code_e  = bt_rsp_e'(rsp_code);

    bt_parity_chk #(
        .ADDR_W (ADDR_W)
    ) u_par (
        .write (err_rec.write),
        .addr  (err_rec.addr),
        .par   (err_rec.par),
        .bad   (perr_now)
    );

    // Per-phase permission to leave, independent of the successor.
    always_comb begin
        gate        = '0;
        gate[0]     = arb_grant;
        gate[1]     = 1'b1;
        gate[P_ERR] = 1'b1;
        gate[P_SNP] = snp_rec.perr || snp_valid;
        gate[P_RSP] = 1'b0;
    end

    // Advance decisions, resolved from the data phase back to arbitration.
    always_comb begin
        to_data  = 1'b0;
        exit_rsp = 1'b0;
        free_v   = '0;
        leave    = '0;
        free_v[N_SLOTS] = !dat_busy || dat_finish;
        if (occ[P_RSP]) begin
            if (rsp_rec.perr) begin
                exit_rsp = !dat_finish;
            end else if (rsp_valid) begin
                if (code_e == RC_NOW) begin
                    to_data = free_v[N_SLOTS];
                end else begin
                    exit_rsp = !dat_finish;
                end
            end
        end
        leave[P_RSP]  = to_data || exit_rsp;
        free_v[P_RSP] = !occ[P_RSP] || leave[P_RSP];
        for (int i = P_RSP - 1; i >= 0; i--) begin
            leave[i]  = occ[i] && gate[i] && free_v[i+1];
            free_v[i] = !occ[i] || leave[i];
        end
    end

    // Next-record contents, adding the error and snoop results on the way.
    always_comb begin
        rec_t r3, r4;
        r3      = err_rec;
        r3.perr = perr_now;
        r4      = snp_rec;
        r4.hit  = snp_rec.perr ? 1'b0 : snp_hit;
        slot_d[0]     = rec_in;
        slot_d[1]     = slot_q[0];
        slot_d[P_ERR] = slot_q[1];
        slot_d[P_SNP] = r3;
        slot_d[P_RSP] = r4;
    end

    assign load[0] = req_valid && free_v[0];
    assign load[N_SLOTS-1:1] = leave[N_SLOTS-2:0];

    genvar g;
    generate
        for (g = 0; g < N_SLOTS; g++) begin : g_slot
            bt_slot #(
                .W (REC_W)
            ) u_slot (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (load[g]),
                .clear (leave[g]),
                .d     (slot_d[g]),
                .q     (slot_q[g]),
                .occ   (occ[g])
            );
        end
    endgenerate

    bt_data_engine #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .TAG_W      (TAG_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (to_data),
        .ld_write  (rsp_rec.write),
        .ld_addr   (rsp_rec.addr),
        .ld_bytes  (rsp_rec.bytes),
        .ld_tag    (rsp_rec.tag),
        .ld_hit    (rsp_rec.hit),
        .dat_ready (dat_ready),
        .busy      (dat_busy),
        .finish    (dat_finish),
        .beat      (dat_beat),
        .cur_write (dat_write),
        .cur_addr  (dat_addr),
        .cur_tag   (dat_tag),
        .cur_hit   (dat_hit)
    );

    // Handshake and occupancy outputs.
    always_comb begin
        req_ready  = free_v[0];
        snp_ack    = leave[P_SNP] && !snp_rec.perr;
        rsp_ack    = leave[P_RSP] && !rsp_rec.perr;
        phase_busy = {dat_busy, occ};
    end

    // Completion port: data finish has priority over a response-phase exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid  <= 1'b0;
            done_tag    <= '0;
            done_status <= ST_OK;
            done_hit    <= 1'b0;
        end else begin
            done_valid <= dat_finish || exit_rsp;
            if (dat_finish) begin
                done_tag    <= dat_tag;
                done_status <= ST_OK;
                done_hit    <= dat_hit;
            end else if (exit_rsp) begin
                done_tag <= rsp_rec.tag;
                done_hit <= rsp_rec.hit;
                if (rsp_rec.perr) begin
                    done_status <= ST_PARITY;
                end else if (code_e == RC_DEFER) begin
                    done_status <= ST_DEFER;
                end else begin
                    done_status <= ST_REFUSE;
                end
            end
        end
    end

endmodule

// File: rtl/bt_phase_tracker_chk.sv
// Assertion checker for the phase tracker, attached by bind.
// Assumes: port names match the tracker's own ports.
module bt_phase_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       arb_grant,
    input logic       snp_valid,
    input logic       snp_ack,
    input logic       rsp_valid,
    input logic       rsp_ack,
    input logic       dat_ready,
    input logic       dat_beat,
    input logic [5:0] phase_busy,
    input logic       done_valid,
    input logic [1:0] done_status
);

    // R3
    req_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> phase_busy[0]);

    // R9
    arb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_busy[0] && !arb_grant) |=> phase_busy[0]);

    // R8
    beat_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_beat |-> (phase_busy[5] && dat_ready));

    // R6
    snoop_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_ack |-> (snp_valid && phase_busy[3]));

    // R7
    resp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> (rsp_valid && phase_busy[4]));

    // R8
    ok_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_status == 2'b00) |-> $past(phase_busy[5]));

endmodule

bind bt_phase_tracker bt_phase_tracker_chk u_chk (.*);

// File: tb/tb_bt_phase_tracker.sv
`timescale 1ns/1ps
module tb_bt_phase_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_par = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_bytes = '0;
    logic [3:0]  req_tag = '0;
    logic        arb_grant = 1'b0, snp_valid = 1'b0, snp_hit = 1'b0;
    logic        rsp_valid = 1'b0, dat_ready = 1'b0;
    logic [1:0]  rsp_code = 2'b00;
    logic        req_ready, snp_ack, rsp_ack, dat_beat, dat_write;
    logic [15:0] dat_addr;
    logic [3:0]  dat_tag, done_tag;
    logic [5:0]  phase_busy;
    logic        done_valid, done_hit;
    logic [1:0]  done_status;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    bt_phase_tracker dut (.*);

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  bytes;
        logic [3:0]  tag;
        logic        badpar;
        logic        hit;
        logic [1:0]  code;
        logic [1:0]  exp_st;
        logic [3:0]  exp_beats;
        logic [3:0]  exp_lat;
        logic        exp_hit;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h1000, 8'd8,  4'd1, 1'b0, 1'b0, 2'b00, 2'b00, 4'd2, 4'd7, 1'b0},
        '{1'b1, 16'h2004, 8'd5,  4'd2, 1'b0, 1'b1, 2'b00, 2'b00, 4'd2, 4'd7, 1'b1},
        '{1'b0, 16'h0040, 8'd16, 4'd3, 1'b0, 1'b0, 2'b00, 2'b00, 4'd4, 4'd9, 1'b0},
        '{1'b1, 16'h3000, 8'd0,  4'd4, 1'b0, 1'b0, 2'b00, 2'b00, 4'd0, 4'd6, 1'b0},
        '{1'b0, 16'h4000, 8'd4,  4'd5, 1'b0, 1'b1, 2'b01, 2'b01, 4'd0, 4'd5, 1'b1},
        '{1'b1, 16'h5000, 8'd12, 4'd6, 1'b0, 1'b0, 2'b10, 2'b11, 4'd0, 4'd5, 1'b0},
        '{1'b0, 16'h6000, 8'd8,  4'd7, 1'b0, 1'b0, 2'b11, 2'b11, 4'd0, 4'd5, 1'b0},
        '{1'b1, 16'h7000, 8'd8,  4'd8, 1'b1, 1'b1, 2'b00, 2'b10, 4'd0, 4'd5, 1'b0},
        '{1'b0, 16'h00FC, 8'd3,  4'd9, 1'b0, 1'b0, 2'b00, 2'b00, 4'd1, 4'd6, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_req(input logic wr, input logic [15:0] a, input logic [7:0] b,
                           input logic [3:0] t, input logic bad);
        req_write = wr;
        req_addr  = a;
        req_bytes = b;
        req_tag   = t;
        req_par   = (^{wr, a}) ^ bad;
        req_valid = 1'b1;
    endtask

    task automatic all_go();
        arb_grant = 1'b1;
        snp_valid = 1'b1;
        rsp_valid = 1'b1;
        dat_ready = 1'b1;
        rsp_code  = 2'b00;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (phase_busy == 6'd0 && !done_valid) break;
        end
    endtask

    // Issue one request and follow it to its completion report.
    task automatic run_one(input vec_t v, input string req);
        int n;
        int beats;
        int bad_addr;
        @(negedge clk);
        all_go();
        snp_hit  = v.hit;
        rsp_code = v.code;
        set_req(v.wr, v.addr, v.bytes, v.tag, v.badpar);
        @(posedge clk);
        n = 0;
        beats = 0;
        bad_addr = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (done_valid) break;
            if (dat_beat) begin
                if (dat_addr !== v.addr + 16'(4 * beats) || dat_write !== v.wr ||
                    dat_tag !== v.tag)
                    bad_addr++;
                beats++;
            end
            n++;
        end
        chk({req, " status"}, 32'(done_status), 32'(v.exp_st));
        chk({req, " tag R11"}, 32'(done_tag), 32'(v.tag));
        chk({req, " hit R6"}, 32'(done_hit), 32'(v.exp_hit));
        chk({req, " beats R8"}, 32'(beats), 32'(v.exp_beats));
        chk({req, " latency R2"}, 32'(n), 32'(v.exp_lat));
        chk({req, " beat address R8"}, 32'(bad_addr), 32'd0);
    endtask

    initial begin
        #4_000_000;
        total++;
        fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk("R1 busy in reset", 32'(phase_busy), 32'd0);
        chk("R1 done in reset", 32'(done_valid), 32'd0);
        chk("R1 ready in reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", 32'(phase_busy), 32'd0);

        // Table walk: R2 R4 R7 R8 outcomes one transaction at a time
        for (int i = 0; i < NV; i++) begin
            string s;
            s = $sformatf("vec%0d R7", i);
            if (VECS[i].badpar) s = $sformatf("vec%0d R4", i);
            run_one(VECS[i], s);
            wait_idle();
        end

        // R5: parity failure passes snoop and response with both valids low
        begin
            int n;
            int acks;
            @(negedge clk);
            all_go();
            snp_valid = 1'b0;
            rsp_valid = 1'b0;
            dat_ready = 1'b0;
            set_req(1'b0, 16'h0123, 8'd8, 4'hA, 1'b1);
            @(posedge clk);
            n = 0;
            acks = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                req_valid = 1'b0;
                if (done_valid) break;
                if (snp_ack || rsp_ack) acks++;
                n++;
            end
            chk("R5 parity skip latency", 32'(n), 32'd5);
            chk("R5 parity skip status", 32'(done_status), 32'h2);
            chk("R5 no acks", 32'(acks), 32'd0);
            wait_idle();
        end

        // R6: snoop waits for snp_valid, then hit is carried to completion
        @(negedge clk);
        all_go();
        snp_valid = 1'b0;
        set_req(1'b1, 16'h0800, 8'd4, 4'hB, 1'b0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (7) @(negedge clk);
        chk("R6 held in snoop", 32'(phase_busy), 32'h08);
        chk("R6 no completion while waiting", 32'(done_valid), 32'd0);
        snp_valid = 1'b1;
        snp_hit = 1'b1;
        #1;
        chk("R6 snoop ack", 32'(snp_ack), 32'd1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done_valid) break;
        end
        chk("R6 hit reported", 32'(done_hit), 32'd1);
        chk("R6 status ok", 32'(done_status), 32'd0);
        snp_hit = 1'b0;
        wait_idle();

        // R3: arbitration stall blocks new requests
        @(negedge clk);
        all_go();
        arb_grant = 1'b0;
        set_req(1'b0, 16'h0900, 8'd4, 4'hC, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R3 ready low while not granted", 32'(req_ready), 32'd0);
        chk("R3 only arbitration busy", 32'(phase_busy), 32'h01);
        req_valid = 1'b0;
        arb_grant = 1'b1;
        wait_idle();

        // R9 R11: six back-to-back requests fill the pipe and finish in order
        @(negedge clk);
        all_go();
        for (int k = 0; k < 6; k++) begin
            set_req(1'b0, 16'(16'h0A00 + 16 * k), 8'd4, 4'(k), 1'b0);
            #1;
            chk("R9 ready for back-to-back", 32'(req_ready), 32'd1);
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R9 all phases busy", 32'(phase_busy), 32'h3F);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R11 completion valid", 32'(done_valid), 32'd1);
            chk("R11 completion order", 32'(done_tag), 32'(k));
        end
        wait_idle();

        // R10: data finish and refusal collide; data wins, refusal waits
        @(negedge clk);
        all_go();
        set_req(1'b0, 16'h0100, 8'd8, 4'hD, 1'b0);
        @(negedge clk);
        set_req(1'b1, 16'h0200, 8'd4, 4'hE, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rsp_valid = 1'b0;
        @(negedge clk);
        chk("R10 response and data busy", 32'(phase_busy), 32'h30);
        rsp_valid = 1'b1;
        rsp_code = 2'b10;
        #1;
        chk("R10 response held", 32'(rsp_ack), 32'd0);
        chk("R10 nothing reported yet", 32'(done_valid), 32'd0);
        @(negedge clk);
        chk("R10 data first valid", 32'(done_valid), 32'd1);
        chk("R10 data first tag", 32'(done_tag), 32'hD);
        chk("R10 data first status", 32'(done_status), 32'd0);
        chk("R10 response taken next", 32'(rsp_ack), 32'd1);
        @(negedge clk);
        chk("R10 refusal valid", 32'(done_valid), 32'd1);
        chk("R10 refusal tag", 32'(done_tag), 32'hE);
        chk("R10 refusal status", 32'(done_status), 32'h3);
        wait_idle();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule